// File: doc/BRIEF.md
# Protection Key Access Checker

This block keeps one thread's protection-key rights word and uses it to judge data memory accesses. Every page carries a small key number. The rights word holds two restriction bits for each possible key. One bit blocks all data access to pages with that key. The other bit blocks only data stores. Software moves a thread between protection domains by rewriting this one word, and the page table entries stay as they are.

Software reads and writes the word through a simple port that stands in for dedicated register instructions. For each access the caller presents the page's key, the access kind and a flag saying whether the core runs in 64-bit mode. One clock later the block returns a strobe with an allow/fault verdict and a cause code. Each thread context instantiates its own copy, and the copies share no state.

Top module: `pkey_guard`

## Requirements
- R1: After reset the rights word reads as zero, so every key is fully accessible, and `res_valid` is low.
- R2: A write on `reg_wr_en` loads `reg_wr_data` into the rights word at the clock edge. `reg_rd_data` shows the stored word from the next cycle on. Without a write the word holds its value.
- R3: For key k, bit 2k of the rights word is the access-disable bit and bit 2k+1 is the write-disable bit. A check looks only at the pair that belongs to its key.
- R4: A data load (`chk_kind` = 0) or data store (`chk_kind` = 1) to a key whose access-disable bit is set gives a fault with cause 1.
- R5: If a key has write-disable set and access-disable clear, a data store gives a fault with cause 2 and a data load is allowed with cause 0.
- R6: If both bits of a key are set, a store reports cause 1, because access-disable takes priority.
- R7: An instruction fetch is always allowed with cause 0, whatever the rights word holds. A fetch is any `chk_kind` with bit 1 set (codes 2 and 3).
- R8: When `chk_long_mode` is low, every access is allowed with cause 0.
- R9: A check presented with `chk_valid` in one cycle gives exactly one cycle of `res_valid` in the next cycle. `res_allow` is high exactly when `res_cause` is 0, and cause 3 never appears.
- R10: A check made in the same cycle as a write uses the rights word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the rights word |
| reg_wr_data | input | 32 | New rights word |
| reg_rd_data | output | 32 | Current rights word |
| chk_valid | input | 1 | An access is presented for checking |
| chk_key | input | 4 | Protection key of the accessed page |
| chk_kind | input | 2 | 0 load, 1 store, 2 or 3 instruction fetch |
| chk_long_mode | input | 1 | High when the core runs in 64-bit mode |
| res_valid | output | 1 | One-cycle strobe marking a verdict |
| res_allow | output | 1 | High when the access may proceed |
| res_cause | output | 2 | 0 none, 1 access-disable fault, 2 write-disable fault |

## Verification
The bench first sweeps all keys with a zero rights word. It then sets a single access-disable bit and a single write-disable bit, each on a different key, and probes the neighbouring keys so that a shifted or swapped bit pair shows up. A key with both bits set, probed with loads, stores, both fetch codes and 64-bit mode off, separates cause priority from the fetch and mode bypasses. A check in the same cycle as a write shows whether the old or the new word was used. A mixed pattern across all keys, run back to back, exercises the result pipeline and confirms that no strobe is lost or added.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

    // Access kind encoding: bit 1 set means instruction fetch
    typedef enum logic [1:0] {
        ACC_LOAD    = 2'd0,
        ACC_STORE   = 2'd1,
        ACC_IFETCH  = 2'd2,
        ACC_IFETCH2 = 2'd3
    } acc_kind_e;

    // Fault cause reported with each verdict
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ACCESS = 2'd1,
        CAUSE_WRITE  = 2'd2
    } fault_cause_e;

    typedef struct packed {
        logic         valid;
        logic         allow;
        fault_cause_e cause;
    } verdict_t;

endpackage

// File: rtl/pkey_rights_reg.sv
module pkey_rights_reg #(
    parameter int unsigned RIGHTS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [RIGHTS_W-1:0] wr_data,
    output logic [RIGHTS_W-1:0] rights_o
);

    typedef struct packed {
        logic [RIGHTS_W-1:0] rights;
    } reg_state_t;

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.rights = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rights_o = state_q.rights;

    AST_RIGHTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(rights_o)); // R2

    AST_RIGHTS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) && $past(rst_n) |-> rights_o == $past(wr_data)); // R2

endmodule

// File: rtl/pkey_eval.sv
module pkey_eval
    import pkey_pkg::*;
#(
    parameter int unsigned NUM_KEYS = 16,
    localparam int unsigned KEY_W    = $clog2(NUM_KEYS),
    localparam int unsigned RIGHTS_W = 2 * NUM_KEYS
) (
    input  logic [RIGHTS_W-1:0] rights_i,
    input  logic [KEY_W-1:0]    key_i,
    input  logic [1:0]          kind_i,
    input  logic                long_mode_i,
    output logic                allow_o,
    output fault_cause_e        cause_o
);

    logic [NUM_KEYS-1:0] acc_dis;
    logic [NUM_KEYS-1:0] wr_dis;

    // Split the rights word into per-key restriction vectors
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_split
        assign acc_dis[k] = rights_i[2*k];
        assign wr_dis[k]  = rights_i[2*k+1];
    end

    logic sel_ad, sel_wd, is_fetch, is_store;

    always_comb begin
        sel_ad   = acc_dis[key_i];
        sel_wd   = wr_dis[key_i];
        is_fetch = kind_i[1];
        is_store = (kind_i == ACC_STORE);
        cause_o  = CAUSE_NONE;
        if (long_mode_i && !is_fetch) begin
            if (sel_ad) begin
                cause_o = CAUSE_ACCESS;
            end else if (sel_wd && is_store) begin
                cause_o = CAUSE_WRITE;
            end
        end
        allow_o = (cause_o == CAUSE_NONE);
    end

endmodule

// File: rtl/pkey_result_stage.sv
module pkey_result_stage
    import pkey_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_allow,
    input  fault_cause_e in_cause,
    output logic         out_valid,
    output logic         out_allow,
    output fault_cause_e out_cause
);

    verdict_t vr_d, vr_q;

    always_comb begin
        vr_d.valid = in_valid;
        vr_d.allow = in_valid ? in_allow : 1'b0;
        vr_d.cause = in_valid ? in_cause : CAUSE_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vr_q <= '0;
        end else begin
            vr_q <= vr_d;
        end
    end

    assign out_valid = vr_q.valid;
    assign out_allow = vr_q.allow;
    assign out_cause = vr_q.cause;

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R9

    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cause != fault_cause_e'(2'd3)); // R9

endmodule

// File: rtl/pkey_guard.sv
module pkey_guard
    import pkey_pkg::*;
#(
    parameter int unsigned NUM_KEYS = 16,
    localparam int unsigned KEY_W    = $clog2(NUM_KEYS),
    localparam int unsigned RIGHTS_W = 2 * NUM_KEYS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [RIGHTS_W-1:0] reg_wr_data,
    output logic [RIGHTS_W-1:0] reg_rd_data,
    input  logic                chk_valid,
    input  logic [KEY_W-1:0]    chk_key,
    input  logic [1:0]          chk_kind,
    input  logic                chk_long_mode,
    output logic                res_valid,
    output logic                res_allow,
    output logic [1:0]          res_cause
);

    logic [RIGHTS_W-1:0] rights;
    logic                ev_allow;
    fault_cause_e        ev_cause;
    fault_cause_e        rs_cause;

    pkey_rights_reg #(.RIGHTS_W(RIGHTS_W)) u_rights (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .rights_o (rights)
    );

    pkey_eval #(.NUM_KEYS(NUM_KEYS)) u_eval (
        .rights_i    (rights),
        .key_i       (chk_key),
        .kind_i      (chk_kind),
        .long_mode_i (chk_long_mode),
        .allow_o     (ev_allow),
        .cause_o     (ev_cause)
    );

    pkey_result_stage u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (chk_valid),
        .in_allow  (ev_allow),
        .in_cause  (ev_cause),
        .out_valid (res_valid),
        .out_allow (res_allow),
        .out_cause (rs_cause)
    );

    assign reg_rd_data = rights;
    assign res_cause   = rs_cause;

    AST_FETCH_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(chk_kind[1]) |-> res_allow); // R7

    AST_MODE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !$past(chk_long_mode) |-> res_allow); // R8

    AST_ALLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_allow == (res_cause == 2'd0))); // R9

    AST_LOAD_NO_WD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(chk_kind) == 2'd0 |-> res_cause != 2'd2); // R5

endmodule

// File: tb/pkey_guard_test.sv
`timescale 1ns/1ps
module pkey_guard_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic [31:0] reg_rd_data;
    logic        chk_valid;
    logic [3:0]  chk_key;
    logic [1:0]  chk_kind;
    logic        chk_long_mode;
    logic        res_valid;
    logic        res_allow;
    logic [1:0]  res_cause;

    int checks = 0;
    int errors = 0;
    logic [31:0] model = '0;
    logic [2:0]  exp_q[$];
    string       req_q[$];

    always #4 clk = ~clk;

    pkey_guard uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .chk_valid(chk_valid), .chk_key(chk_key), .chk_kind(chk_kind),
        .chk_long_mode(chk_long_mode),
        .res_valid(res_valid), .res_allow(res_allow), .res_cause(res_cause)
    );

    function automatic logic [2:0] predict(input logic [31:0] r, input logic [3:0] k,
                                           input logic [1:0] kind, input logic mode);
        logic [1:0] c;
        c = 2'd0;
        if (mode && !kind[1]) begin
            if (r[2*k]) c = 2'd1;
            else if (r[2*k+1] && kind == 2'd1) c = 2'd2;
        end
        return {c == 2'd0, c};
    endfunction

    task automatic step(input logic do_wr, input logic [31:0] wd, input logic do_chk,
                        input logic [3:0] k, input logic [1:0] kind, input logic mode,
                        input string req);
        reg_wr_en     = do_wr;
        reg_wr_data   = wd;
        chk_valid     = do_chk;
        chk_key       = k;
        chk_kind      = kind;
        chk_long_mode = mode;
        if (do_chk) begin
            exp_q.push_back(predict(model, k, kind, mode));
            req_q.push_back(req);
        end
        if (do_wr) model = wd;
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk_valid = 1'b0;
    endtask

    task automatic check_rd(input string req);
        checks++;
        if (reg_rd_data !== model) begin
            errors++;
            $display("FAIL %s: rights readback actual %h expected %h", req, reg_rd_data, model);
        end
    endtask

    // Monitor: pops the scoreboard whenever a verdict strobe appears
    always @(negedge clk) begin
        if (rst_n === 1'b1 && res_valid === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9: unexpected strobe actual allow=%b cause=%0d expected none",
                         res_allow, res_cause);
            end else begin
                logic [2:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if ({res_allow, res_cause} !== e) begin
                    errors++;
                    $display("FAIL %s: actual allow=%b cause=%0d expected allow=%b cause=%0d",
                             r, res_allow, res_cause, e[2], e[1:0]);
                end
            end
        end
    end

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr_en = 0; reg_wr_data = '0; chk_valid = 0;
        chk_key = '0; chk_kind = '0; chk_long_mode = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: res_valid actual %b expected 0", res_valid);
        end
        check_rd("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3: zero word allows all keys for loads and stores
        for (int k = 0; k < 16; k++) begin
            step(0, '0, 1, 4'(k), 2'd1, 1, "R1 store zero word");
            step(0, '0, 1, 4'(k), 2'd0, 1, "R1 load zero word");
        end

        // R2 R4: access-disable on key 3 (bit 6)
        step(1, 32'h0000_0040, 0, 0, 0, 1, "");
        check_rd("R2");
        step(0, '0, 1, 4'd3, 2'd0, 1, "R4 load AD key");
        step(0, '0, 1, 4'd3, 2'd1, 1, "R4 store AD key");
        step(0, '0, 1, 4'd2, 2'd1, 1, "R3 neighbour key 2");
        step(0, '0, 1, 4'd4, 2'd0, 1, "R3 neighbour key 4");

        // R5: write-disable on key 5 (bit 11)
        step(1, 32'h0000_0800, 0, 0, 0, 1, "");
        check_rd("R2");
        step(0, '0, 1, 4'd5, 2'd0, 1, "R5 load WD key");
        step(0, '0, 1, 4'd5, 2'd1, 1, "R5 store WD key");
        step(0, '0, 1, 4'd6, 2'd1, 1, "R3 neighbour key 6");

        // R6: both bits on key 15
        step(1, 32'hC000_0000, 0, 0, 0, 1, "");
        check_rd("R2");
        step(0, '0, 1, 4'd15, 2'd1, 1, "R6 store both bits");
        step(0, '0, 1, 4'd15, 2'd0, 1, "R6 load both bits");
        // R7 fetch bypass, both codes
        step(0, '0, 1, 4'd15, 2'd2, 1, "R7 fetch code 2");
        step(0, '0, 1, 4'd15, 2'd3, 1, "R7 fetch code 3");
        // R8 mode bypass
        step(0, '0, 1, 4'd15, 2'd1, 0, "R8 store mode off");
        step(0, '0, 1, 4'd15, 2'd0, 0, "R8 load mode off");

        // R10: same-cycle write uses the old word
        step(1, 32'h0000_0000, 1, 4'd15, 2'd1, 1, "R10 check with write");
        step(0, '0, 1, 4'd15, 2'd1, 1, "R10 check after write");
        check_rd("R2 hold");

        // R9 back-to-back with a mixed pattern across all keys
        step(1, 32'h9C36_A5E1, 0, 0, 0, 1, "");
        for (int k = 0; k < 16; k++) begin
            step(0, '0, 1, 4'(k), 2'(k % 3), 1, "R9 mixed pattern");
        end
        step(0, '0, 0, 0, 0, 1, "");
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9: strobe after idle actual %b expected 0", res_valid);
        end
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: missing verdicts actual %0d pending expected 0", exp_q.size());
        end
        check_rd("R2 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule